// File: doc/BRIEF.md
# Serial Transmit Segment Deserializer

This block sits on the PHY side of a serial media-independent link. It watches the transmit data line, one bit per reference clock. A segment is ten bits long. A SYNC pulse from the MAC marks the first bit of each segment. The block rebuilds each segment into the MII transmit controls (transmit error and transmit enable) and one data byte. It presents them together with a valid strobe that lasts one cycle.

A speed input chooses how segments become bytes:

- **100 Mbit/s mode:** every completed segment carries a fresh byte.
- **10 Mbit/s mode:** the MAC repeats each segment ten times. The block keeps one copy out of each group of ten and drops the other nine. A frame start (transmit enable rising between two completed segments) restarts the group, so the opening byte of a frame is never lost.

A SYNC pulse that lands inside a segment realigns the bit counter to that pulse. The partial segment in progress is thrown away.

Top module: `txseg_deser`

## Requirements
- R1: A segment starts only in a cycle where `seg_sync_i` is high; the bit on `ser_i` in that cycle is segment bit 0. Bits 1 to 9 follow on the next nine cycles. Bit 0 is transmit error, bit 1 is transmit enable, and bits 2 to 9 are data bits 0 to 7, least significant first.
- R2: When the tenth bit of a kept segment is presented in cycle N, `byte_vld_o` is high in cycle N+1 only. In that same cycle, `byte_o`, `tx_en_o` and `tx_er_o` show that segment's fields.
- R3: After reset, all outputs are 0. Between strobes, `byte_o`, `tx_en_o` and `tx_er_o` hold their last values.
- R4: With `speed_fast_i` = 1, every completed segment produces a strobe.
- R5: With `speed_fast_i` = 0, the block keeps one completed segment and then drops the next nine. Counting of completed segments continues across drops, and holding `speed_fast_i` at 1 clears the count.
- R6: With `speed_fast_i` = 0, a completed segment whose transmit enable is 1 is always kept when the previous completed segment had transmit enable 0. That segment starts a new group of ten.
- R7: A `seg_sync_i` pulse during bits 1 to 9 of a segment discards that partial segment without a strobe. The pulse itself starts a new segment as bit 0.
- R8: Bits that arrive while no segment is open produce no strobe, including bits before the first SYNC and bits after a completed segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the serial line is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_fast_i | input | 1 | 1 selects 100 Mbit/s, 0 selects 10 Mbit/s |
| seg_sync_i | input | 1 | Segment start pulse from the MAC |
| ser_i | input | 1 | Serial transmit line |
| byte_vld_o | output | 1 | One-cycle strobe for a new byte |
| tx_en_o | output | 1 | Rebuilt transmit enable |
| tx_er_o | output | 1 | Rebuilt transmit error |
| byte_o | output | 8 | Rebuilt data byte |

## Verification
The assertions assume that `speed_fast_i` changes only while no segment is being completed. They also assume that any two SYNC pulses that complete segments are at least ten cycles apart, which is what makes a strobe last a single cycle. The stimulus changes speed only between segments. It opens each segment with exactly one SYNC pulse and leaves an idle cycle after the tenth bit. Early SYNC pulses are injected only as truncated segments followed by a full one.

// File: rtl/txseg_pkg.sv
package txseg_pkg;

  localparam int unsigned CTRL_BITS = 2;

  typedef struct packed {
    logic       er;
    logic       en;
    logic [7:0] data;
  } seg_fields_t;

  // split a ten-bit segment word (bit 0 first on the wire)
  function automatic seg_fields_t seg_unpack(input logic [9:0] w);
    seg_fields_t f;
    f.er   = w[0];
    f.en   = w[1];
    f.data = w[9:2];
    return f;
  endfunction

  // wrap-around increment used by the segment group counter
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/txseg_align.sv
module txseg_align #(
  parameter int unsigned SEG_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             ser_i,
  output logic             seg_done_o,
  output logic             resync_o,
  output logic [SEG_W-1:0] seg_word_o
);
  localparam int unsigned PW   = $clog2(SEG_W);
  localparam int unsigned LAST = SEG_W - 1;

  logic [PW-1:0]    pos_q;
  logic             open_q;
  logic [SEG_W-2:0] hold_q;

  // tenth bit on the line, no competing SYNC
  assign seg_done_o = open_q && (pos_q == PW'(LAST)) && !sync_i;
  // SYNC while a segment is still open: partial gets discarded
  assign resync_o   = open_q && sync_i;
  assign seg_word_o = {ser_i, hold_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      open_q <= 1'b0;
    end else if (sync_i) begin
      pos_q  <= PW'(1);
      open_q <= 1'b1;
    end else if (open_q) begin
      if (pos_q == PW'(LAST)) begin
        pos_q  <= '0;
        open_q <= 1'b0;
      end else begin
        pos_q <= pos_q + PW'(1);
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < SEG_W - 1; gi++) begin : g_cap
      logic take_bit;
      if (gi == 0) begin : g_first
        assign take_bit = sync_i;
      end else begin : g_rest
        assign take_bit = !sync_i && open_q && (pos_q == PW'(gi));
      end
      always_ff @(posedge clk) begin
        if (!rst_n)        hold_q[gi] <= 1'b0;
        else if (take_bit) hold_q[gi] <= ser_i;
      end
    end
  endgenerate

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= PW'(LAST)); // R1
  AST_DONE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done_o |=> !seg_done_o); // R2
  AST_RESYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    resync_o |=> !seg_done_o); // R7
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |-> !seg_done_o); // R8

endmodule

// File: rtl/txseg_pick.sv
module txseg_pick #(
  parameter int unsigned REPEAT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_i,
  input  logic done_i,
  input  logic en_i,
  output logic take_o,
  output logic restart_o
);
  import txseg_pkg::*;

  localparam int unsigned CW = (REPEAT > 1) ? $clog2(REPEAT) : 1;

  logic prev_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      prev_en_q <= 1'b0;
    else if (done_i) prev_en_q <= en_i;
  end

  // frame start seen on a completed segment in slow mode
  assign restart_o = done_i && !fast_i && en_i && !prev_en_q;

  generate
    if (REPEAT == 1) begin : g_norep
      assign take_o = done_i;
    end else begin : g_rep
      logic [CW-1:0] cnt_q;
      logic          head;

      assign head   = (cnt_q == '0);
      assign take_o = done_i && (fast_i || restart_o || head);

      always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (fast_i)    cnt_q <= '0;
        else if (restart_o) cnt_q <= CW'(wrap_inc(0, REPEAT));
        else if (done_i)    cnt_q <= CW'(wrap_inc(int'(cnt_q), REPEAT));
      end

      AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(REPEAT)); // R5
      AST_SLOW_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !fast_i) |=> (cnt_q == CW'(1))); // R5
      AST_FAST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fast_i |=> head); // R5
    end
  endgenerate

endmodule

// File: rtl/txseg_outreg.sv
module txseg_outreg #(
  parameter int unsigned SEG_W  = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [SEG_W-1:0]  word_i,
  output logic              vld_o,
  output logic              en_o,
  output logic              er_o,
  output logic [DATA_W-1:0] data_o
);
  import txseg_pkg::*;

  seg_fields_t f;
  assign f = seg_unpack(word_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      en_o   <= 1'b0;
      er_o   <= 1'b0;
      data_o <= '0;
    end else begin
      vld_o <= load_i;
      if (load_i) begin
        en_o   <= f.en;
        er_o   <= f.er;
        data_o <= f.data;
      end
    end
  end

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(data_o) && $stable(en_o) && $stable(er_o))); // R3
  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> $past(load_i)); // R2

endmodule

// File: rtl/txseg_deser.sv
module txseg_deser #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REPEAT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              speed_fast_i,
  input  logic              seg_sync_i,
  input  logic              ser_i,
  output logic              byte_vld_o,
  output logic              tx_en_o,
  output logic              tx_er_o,
  output logic [DATA_W-1:0] byte_o
);
  import txseg_pkg::*;

  localparam int unsigned SEG_W = DATA_W + CTRL_BITS;

  logic             seg_done;
  logic             resync;
  logic [SEG_W-1:0] seg_word;
  logic             take;
  logic             restart;

  txseg_align #(.SEG_W(SEG_W)) u_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_i     (seg_sync_i),
    .ser_i      (ser_i),
    .seg_done_o (seg_done),
    .resync_o   (resync),
    .seg_word_o (seg_word)
  );

  txseg_pick #(.REPEAT(REPEAT)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_i    (speed_fast_i),
    .done_i    (seg_done),
    .en_i      (seg_word[1]),
    .take_o    (take),
    .restart_o (restart)
  );

  txseg_outreg #(.SEG_W(SEG_W), .DATA_W(DATA_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (take),
    .word_i (seg_word),
    .vld_o  (byte_vld_o),
    .en_o   (tx_en_o),
    .er_o   (tx_er_o),
    .data_o (byte_o)
  );

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |=> !byte_vld_o); // R2
  AST_FAST_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_fast_i && seg_done) |=> byte_vld_o); // R4
  AST_RESTART_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (byte_vld_o && tx_en_o)); // R6
  AST_RESYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !byte_vld_o); // R7

endmodule

// File: tb/txseg_deser_test.sv
`timescale 1ns/1ps
module txseg_deser_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast = 1'b1;
  logic sync = 1'b0;
  logic ser = 1'b0;
  logic       vld, en, er;
  logic [7:0] data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench copy of the decimation state
  bit       m_prev;
  int       m_phase;
  bit [7:0] m_data;
  bit       m_en, m_er;

  always #2.5 clk = ~clk;

  txseg_deser uut (
    .clk(clk), .rst_n(rst_n), .speed_fast_i(fast), .seg_sync_i(sync),
    .ser_i(ser), .byte_vld_o(vld), .tx_en_o(en), .tx_er_o(er), .byte_o(data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // is a completed segment kept? (R4, R5, R6)
  function automatic bit keep_seg(input bit f, input bit e, input bit p, input int ph);
    if (f) return 1;
    if (e && !p) return 1;
    return ph == 0;
  endfunction

  function automatic int next_phase(input bit f, input bit e, input bit p, input int ph);
    if (f) return 0;
    if (e && !p) return 1;
    return (ph == 9) ? 0 : ph + 1;
  endfunction

  task automatic send_seg(input bit t_er, input bit t_en, input bit [7:0] d);
    bit [9:0] w;
    bit k;
    w = {d, t_en, t_er};
    k = keep_seg(fast, t_en, m_prev, m_phase);
    m_phase = next_phase(fast, t_en, m_prev, m_phase);
    m_prev = t_en;
    for (int b = 0; b < 10; b++) begin
      @(negedge clk);
      if (b == 0) chk(vld == 1'b0, "R2 strobe width", vld, 0);
      sync = (b == 0);
      ser  = w[b];
    end
    @(negedge clk);
    sync = 1'b0;
    ser  = $urandom_range(0, 1);
    chk(vld == k, k ? "R4/R5/R6 kept segment strobe" : "R5 dropped copy", vld, k);
    if (k) begin
      m_data = d; m_en = t_en; m_er = t_er;
    end
    chk(data == m_data, "R1 data byte", data, m_data);
    chk({en, er} == {m_en, m_er}, "R1 enable/error (R3 hold)", {en, er}, {m_en, m_er});
  endtask

  task automatic send_partial(input int n);
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      if (b > 0) chk(vld == 1'b0, "R7 partial quiet", vld, 0);
      sync = (b == 0);
      ser  = $urandom_range(0, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    m_prev = 0; m_phase = 0; m_data = 0; m_en = 0; m_er = 0;
    repeat (4) @(negedge clk);
    chk({vld, en, er, data} == 11'd0, "R3 reset state", {vld, en, er, data}, 0);
    rst_n = 1'b1;

    // R8: bits with no SYNC never make a strobe
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      ser = $urandom_range(0, 1);
      chk(vld == 1'b0, "R8 no sync", vld, 0);
    end

    // R1/R4 directed: bit order
    fast = 1'b1;
    send_seg(1'b1, 1'b0, 8'h01);
    send_seg(1'b0, 1'b1, 8'h80);
    send_seg(1'b0, 1'b1, 8'hA5);
    // R8: idle after a completed segment
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      ser = 1'b1;
      chk(vld == 1'b0, "R8 idle after segment", vld, 0);
    end
    // R4 random
    for (int i = 0; i < 60; i++)
      send_seg($urandom_range(0, 1), $urandom_range(0, 1), 8'($urandom));

    // R7: early SYNC discards partials
    for (int i = 0; i < 12; i++) begin
      send_partial($urandom_range(1, 9));
      send_seg(1'b0, 1'b1, 8'($urandom));
    end

    // R5/R6: slow mode, frames with repeated copies
    send_seg(1'b0, 1'b0, 8'h00);
    fast = 1'b0;
    for (int fr = 0; fr < 6; fr++) begin
      int nb = $urandom_range(1, 4);
      for (int i = 0; i < 1 + $urandom_range(0, 12); i++)
        send_seg(1'b0, 1'b0, 8'h00);
      for (int by = 0; by < nb; by++) begin
        bit [7:0] d = 8'($urandom);
        bit e = $urandom_range(0, 3) == 0;
        for (int c = 0; c < 10; c++) send_seg(e, 1'b1, d);
      end
      // misaligned extra copies then re-start: R6 restart mid-group
      for (int c = 0; c < 3; c++) send_seg(1'b0, 1'b1, 8'h5A);
    end
    // R6 directed: enable rises at a non-zero phase
    for (int c = 0; c < 4; c++) send_seg(1'b0, 1'b0, 8'h00);
    send_seg(1'b0, 1'b1, 8'hC3);
    // R5 directed: random stream in slow mode
    for (int i = 0; i < 40; i++)
      send_seg($urandom_range(0, 1), $urandom_range(0, 1), 8'($urandom));

    // back to fast clears phase (R5)
    fast = 1'b1;
    send_seg(1'b0, 1'b1, 8'h3C);
    send_seg(1'b0, 1'b1, 8'hE7);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule